// File: doc/BRIEF.md
# Software Inter-Processor Interrupt Controller

This block is a memory-mapped interrupt controller whose only job is to carry software interrupts from one hart to another. Every hart owns exactly one interrupt source: hart X is reached through source X+1, and source 0 does not exist. A sender sets the target's source pending by writing a one into the pending array. Each hart has a context that holds an enable array and a claim/complete register. Each source has a priority register.

A hart's machine software interrupt line is high while its context sees a source that is pending, enabled, given a non-zero priority and not already in service. The hart reads its claim register to receive the winning source ID. That read clears the source's pending bit and marks the source in service, so the line drops. Writing the same ID back ends the service. All register traffic uses a simple word-wide bus with one access per cycle. Read data returns one cycle after the request.

Top module: `sipi_ctrl`

## Requirements
- R1: Source ID 0 does not exist. Its pending bit (bit 0 of pending word 0) and its enable bit (bit 0 of enable word 0 of every context) always read as 0, and writes to them have no effect.
- R2: A write to pending word w (address 0x1000 + 4w) sets source 32w+b pending for every bit b written as one. Bits written as zero leave pending state unchanged. A pending bit stays set until a claim takes that source. Reading the word returns the pending bits at the same positions.
- R3: Enable word w of context c is at address 0x2000 + 0x80·c + 4w. It is read/write, and bit b enables source 32w+b for that context only.
- R4: The priority of source s is at address 4s. It keeps the low PRIO_W bits of the written data and reads back zero-extended. A fresh reset leaves every priority at 0.
- R5: msip[c] is high exactly when at least one source is pending, enabled in context c, has non-zero priority and is not in service. All msip lines are low after reset.
- R6: A read of the claim register of context c (address 0x4000 + 0x100·c + 4) returns the ID of the qualifying source with the highest priority. Ties go to the lowest ID. If no source qualifies, the read returns 0.
- R7: A claim that returns a non-zero ID clears that source's pending bit and puts it in service. A source in service is not delivered to any context, even if it is set pending again.
- R8: Writing a source ID to the claim register of context c ends the service of that source, but only if the source is enabled in context c. Other IDs, including 0 and IDs of disabled sources, are ignored.
- R9: The following accesses read as 0 and ignore writes: contexts at or beyond NUM_HARTS, sources or words beyond the last source, addresses with bits [1:0] not zero, and unmapped addresses.
- R10: bus_rvalid is high in the cycle after a read request and low after any other cycle. bus_rdata holds the read data in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 16 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| msip | output | NUM_HARTS | Machine software interrupt line per hart |

## Verification
The bench uses 36 harts so that sources fall into two pending and enable words. Claims are tried with equal priorities, which shows whether ties go to the lowest ID, and with one higher priority, which shows whether the winner is chosen by priority rather than by ID. Other directed cases cover zero priority, re-raising a source that is in service, completion from a context that does not enable the source, source 0, and contexts beyond the hart count. Each of these separates one qualifying condition from the others. A long random mix of pending writes, enable and priority writes, claims and completions follows. After every access the bench compares all msip lines and each read against a reference model kept in the bench.

// File: rtl/sipi_pkg.sv
package sipi_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 32;

    // Address map fields
    localparam int IDX_W  = 10;   // source or word index taken from the address
    localparam int CTX_W  = 6;    // context field width
    localparam int WORD_B = 5;    // bits of the word index inside one enable block

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_CLAIM
    } region_e;

endpackage

// File: rtl/sipi_decode.sv
module sipi_decode
    import sipi_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    output region_e           rgn,
    output logic [IDX_W-1:0]  idx,
    output logic [CTX_W-1:0]  ctx
);

    always_comb begin
        rgn = RG_NONE;
        idx = '0;
        ctx = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr[15:12] == 4'h0) begin
                rgn = RG_PRIO;
                idx = addr[11:2];
            end else if (addr[15:12] == 4'h1) begin
                rgn = RG_PEND;
                idx = addr[11:2];
            end else if (addr[15:13] == 3'b001) begin
                rgn = RG_EN;
                ctx = addr[12:7];
                idx = {{(IDX_W-WORD_B){1'b0}}, addr[6:2]};
            end else if (addr[15:14] == 2'b01 && addr[7:0] == 8'h04) begin
                rgn = RG_CLAIM;
                ctx = addr[13:8];
            end
        end
    end

endmodule

// File: rtl/sipi_claim_arb.sv
module sipi_claim_arb #(
    parameter int NSRC   = 5,
    parameter int PRIO_W = 3
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic [$clog2(NSRC)-1:0]     best_id,
    output logic                        any
);

    localparam int IDW = $clog2(NSRC);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare: an equal priority never
    // replaces an earlier winner, so ties resolve to the lowest ID.
    always_comb begin
        best_p  = '0;
        best_id = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (cand[s] && prio[s] > best_p) begin
                best_p  = prio[s];
                best_id = IDW'(s);
            end
        end
        any = |cand;
    end

endmodule

// File: rtl/sipi_ctrl.sv
module sipi_ctrl
    import sipi_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int PRIO_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    output logic [NUM_HARTS-1:0] msip
);

    localparam int NSRC = NUM_HARTS + 1;
    localparam int IDW  = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0]                 pend;
        logic [NSRC-1:0]                 act;
        logic [NSRC-1:0][PRIO_W-1:0]     prio;
        logic [NUM_HARTS-1:0][NSRC-1:0]  en;
        logic [BUS_DW-1:0]               rdata;
        logic                            rvalid;
    } state_t;

    state_t s_d, s_q;

    region_e          rgn;
    logic [IDX_W-1:0] idx;
    logic [CTX_W-1:0] ctx;

    sipi_decode u_dec (
        .addr (bus_addr),
        .rgn  (rgn),
        .idx  (idx),
        .ctx  (ctx)
    );

    logic [NSRC-1:0]                prio_nz;
    logic [NUM_HARTS-1:0][NSRC-1:0] cand;
    logic [NUM_HARTS-1:0][IDW-1:0]  best_id;
    logic [NUM_HARTS-1:0]           any;

    for (genvar s = 0; s < NSRC; s++) begin : g_pnz
        assign prio_nz[s] = |s_q.prio[s];
    end

    for (genvar c = 0; c < NUM_HARTS; c++) begin : g_ctx
        assign cand[c] = s_q.pend & s_q.en[c] & ~s_q.act & prio_nz;

        sipi_claim_arb #(
            .NSRC   (NSRC),
            .PRIO_W (PRIO_W)
        ) u_arb (
            .cand    (cand[c]),
            .prio    (s_q.prio),
            .best_id (best_id[c]),
            .any     (any[c])
        );

        assign msip[c] = any[c];
    end

    // Claim access of a real context, and the ID it would take
    logic           claim_rd;
    logic [IDW-1:0] take_id;
    logic           take_any;

    always_comb begin
        claim_rd = bus_en && !bus_we && rgn == RG_CLAIM && int'(ctx) < NUM_HARTS;
        take_id  = '0;
        take_any = 1'b0;
        for (int c = 0; c < NUM_HARTS; c++) begin
            if (int'(ctx) == c) begin
                take_id  = best_id[c];
                take_any = any[c];
            end
        end
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = bus_en && !bus_we;
        s_d.rdata  = '0;
        if (bus_en) begin
            unique case (rgn)
                RG_PRIO: begin
                    for (int s = 1; s < NSRC; s++) begin
                        if (int'(idx) == s) begin
                            if (bus_we) s_d.prio[s] = bus_wdata[PRIO_W-1:0];
                            else        s_d.rdata   = BUS_DW'(s_q.prio[s]);
                        end
                    end
                end
                RG_PEND: begin
                    for (int s = 1; s < NSRC; s++) begin
                        if (int'(idx) == s / 32) begin
                            if (bus_we) begin
                                if (bus_wdata[s % 32]) s_d.pend[s] = 1'b1;
                            end else begin
                                s_d.rdata[s % 32] = s_q.pend[s];
                            end
                        end
                    end
                end
                RG_EN: begin
                    for (int c = 0; c < NUM_HARTS; c++) begin
                        for (int s = 1; s < NSRC; s++) begin
                            if (int'(ctx) == c && int'(idx) == s / 32) begin
                                if (bus_we) s_d.en[c][s]      = bus_wdata[s % 32];
                                else        s_d.rdata[s % 32] = s_q.en[c][s];
                            end
                        end
                    end
                end
                RG_CLAIM: begin
                    for (int c = 0; c < NUM_HARTS; c++) begin
                        if (int'(ctx) == c) begin
                            if (!bus_we) begin
                                s_d.rdata = BUS_DW'(best_id[c]);
                                for (int s = 1; s < NSRC; s++) begin
                                    if (any[c] && best_id[c] == IDW'(s)) begin
                                        s_d.pend[s] = 1'b0;
                                        s_d.act[s]  = 1'b1;
                                    end
                                end
                            end else begin
                                for (int s = 1; s < NSRC; s++) begin
                                    if (bus_wdata == BUS_DW'(s) && s_q.en[c][s])
                                        s_d.act[s] = 1'b0;
                                end
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata  = s_q.rdata;
    assign bus_rvalid = s_q.rvalid;

    // ---------------- assertions ----------------
    AST_RVALID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we) |=> bus_rvalid);                             // R10
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |=> !bus_rvalid);                           // R10
    AST_SRC0_PEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && rgn == RG_PEND && idx == '0) |=> !bus_rdata[0]); // R1
    AST_CLAIM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !take_any) |=> (bus_rdata == '0));                  // R6
    AST_CLAIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && take_any) |=> (bus_rdata != '0));                   // R6

    for (genvar s = 1; s < NSRC; s++) begin : g_src_chk
        AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_rd && take_any && take_id == IDW'(s)) |=> (!s_q.pend[s] && s_q.act[s])); // R7
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.pend[s] && !(claim_rd && take_any && take_id == IDW'(s))) |=> s_q.pend[s]); // R2
    end

    for (genvar c = 0; c < NUM_HARTS; c++) begin : g_ctx_chk
        AST_MSIP_ARB: assert property (@(posedge clk) disable iff (!rst_n)
            msip[c] == (best_id[c] != '0));                                // R5
    end

endmodule

// File: tb/sipi_ctrl_tb_top.sv
module sipi_ctrl_tb_top;

    localparam int NH = 36;
    localparam int PW = 3;
    localparam int NS = NH + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NH-1:0] msip;

    always #2 clk = ~clk;   // 250 MHz

    sipi_ctrl #(.NUM_HARTS(NH), .PRIO_W(PW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .msip       (msip)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // reference model
    bit m_pend [NS];
    bit m_act  [NS];
    int m_prio [NS];
    bit m_en   [NH][NS];
    int last_claim [NH];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_best(input int c);
        int best = 0;
        int bp = 0;
        for (int s = 1; s < NS; s++)
            if (m_pend[s] && m_en[c][s] && !m_act[s] && m_prio[s] > bp) begin
                bp = m_prio[s];
                best = s;
            end
        return best;
    endfunction

    function automatic logic [NH-1:0] exp_msip();
        logic [NH-1:0] v;
        for (int c = 0; c < NH; c++) v[c] = (exp_best(c) != 0);
        return v;
    endfunction

    function automatic logic [15:0] a_prio(input int s);  return 16'(4 * s);                         endfunction
    function automatic logic [15:0] a_pend(input int w);  return 16'(32'h1000 + 4 * w);              endfunction
    function automatic logic [15:0] a_en(input int c, input int w); return 16'(32'h2000 + 128 * c + 4 * w); endfunction
    function automatic logic [15:0] a_claim(input int c); return 16'(32'h4000 + 256 * c + 4);         endfunction

    task automatic bus_op(input bit we, input logic [15:0] a, input logic [31:0] d, output logic [31:0] rd);
        bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        rd = bus_rdata;
        if (!we) chk(bus_rvalid == 1'b1, "R10 rvalid after read", 64'(bus_rvalid), 64'd1);
        bus_en = 1'b0; bus_we = 1'b0;
        chk(msip == exp_msip(), "R5 msip", 64'(msip), 64'(exp_msip()));
    endtask

    task automatic wr_pend(input int w, input logic [31:0] d);
        logic [31:0] rd;
        for (int b = 0; b < 32; b++)
            if (d[b] && w * 32 + b >= 1 && w * 32 + b < NS) m_pend[w * 32 + b] = 1'b1;
        bus_op(1'b1, a_pend(w), d, rd);
    endtask

    task automatic wr_en(input int c, input int w, input logic [31:0] d);
        logic [31:0] rd;
        if (c < NH)
            for (int b = 0; b < 32; b++)
                if (w * 32 + b >= 1 && w * 32 + b < NS) m_en[c][w * 32 + b] = d[b];
        bus_op(1'b1, a_en(c, w), d, rd);
    endtask

    task automatic wr_prio(input int s, input logic [31:0] v);
        logic [31:0] rd;
        if (s >= 1 && s < NS) m_prio[s] = int'(v[PW-1:0]);
        bus_op(1'b1, a_prio(s), v, rd);
    endtask

    task automatic rd_pend(input int w, input string req);
        logic [31:0] rd, e;
        e = '0;
        for (int b = 0; b < 32; b++)
            if (w * 32 + b >= 1 && w * 32 + b < NS) e[b] = m_pend[w * 32 + b];
        bus_op(1'b0, a_pend(w), '0, rd);
        chk(rd == e, req, 64'(rd), 64'(e));
    endtask

    task automatic rd_en(input int c, input int w, input string req);
        logic [31:0] rd, e;
        e = '0;
        if (c < NH)
            for (int b = 0; b < 32; b++)
                if (w * 32 + b >= 1 && w * 32 + b < NS) e[b] = m_en[c][w * 32 + b];
        bus_op(1'b0, a_en(c, w), '0, rd);
        chk(rd == e, req, 64'(rd), 64'(e));
    endtask

    task automatic rd_prio(input int s, input string req);
        logic [31:0] rd, e;
        e = (s >= 1 && s < NS) ? 32'(m_prio[s]) : 32'd0;
        bus_op(1'b0, a_prio(s), '0, rd);
        chk(rd == e, req, 64'(rd), 64'(e));
    endtask

    task automatic claim(input int c, input string req);
        logic [31:0] rd;
        int e;
        e = (c < NH) ? exp_best(c) : 0;
        if (e != 0) begin
            m_pend[e] = 1'b0;
            m_act[e]  = 1'b1;
            last_claim[c] = e;
        end
        bus_op(1'b0, a_claim(c), '0, rd);
        chk(rd == 32'(e), req, 64'(rd), 64'(e));
    endtask

    task automatic complete(input int c, input int id);
        logic [31:0] rd;
        if (c < NH && id >= 1 && id < NS && m_en[c][id]) m_act[id] = 1'b0;
        bus_op(1'b1, a_claim(c), 32'(id), rd);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd2024));
        for (int s = 0; s < NS; s++) begin m_pend[s] = 0; m_act[s] = 0; m_prio[s] = 0; end
        for (int c = 0; c < NH; c++) begin
            last_claim[c] = 0;
            for (int s = 0; s < NS; s++) m_en[c][s] = 0;
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(msip == '0, "R5 msip low after reset", 64'(msip), 64'd0);
        chk(bus_rvalid == 1'b0, "R10 rvalid low after reset", 64'(bus_rvalid), 64'd0);
        claim(0, "R6 empty claim after reset");
        rd_prio(1, "R4 priority reset value");

        // R1: source 0 bits cannot be set
        wr_pend(0, 32'h1);
        rd_pend(0, "R1 pending bit 0 stays 0");
        wr_en(0, 0, 32'h1);
        rd_en(0, 0, "R1 enable bit 0 stays 0");
        wr_prio(0, 32'h7);
        rd_prio(0, "R1 source 0 priority reads 0");

        // R4: only low bits stored
        wr_prio(1, 32'hFFFF_FFFA);
        rd_prio(1, "R4 priority truncation");
        chk(m_prio[1] == 2, "R4 model truncation", 64'(m_prio[1]), 64'd2);

        // R5: zero priority blocks delivery
        wr_prio(1, 32'h0);
        wr_en(0, 0, 32'h0000_000E);
        wr_pend(0, 32'h2);
        chk(msip[0] == 1'b0, "R5 zero priority not delivered", 64'(msip[0]), 64'd0);
        claim(0, "R6 zero priority claim returns 0");

        // R6: tie to lowest ID, then priority order
        wr_prio(1, 32'd2);
        wr_prio(2, 32'd2);
        wr_prio(3, 32'd5);
        wr_pend(0, 32'h6);
        chk(msip[0] == 1'b1, "R5 msip raised", 64'(msip[0]), 64'd1);
        claim(0, "R6 tie lowest ID");
        chk(last_claim[0] == 1, "R6 tie returns source 1", 64'(last_claim[0]), 64'd1);
        wr_pend(0, 32'h8);
        claim(0, "R6 highest priority wins");
        chk(last_claim[0] == 3, "R6 priority 5 source 3", 64'(last_claim[0]), 64'd3);
        claim(0, "R6 remaining source 2");
        chk(msip[0] == 1'b0, "R7 msip drops after claims", 64'(msip[0]), 64'd0);
        rd_pend(0, "R7 claimed pending bits cleared");

        // R7/R8: in service blocks redelivery until an enabled completion
        wr_pend(0, 32'h2);
        chk(msip[0] == 1'b0, "R7 in-service source not delivered", 64'(msip[0]), 64'd0);
        claim(0, "R7 in-service claim returns 0");
        complete(1, 1);
        claim(0, "R8 completion from disabled context ignored");
        complete(0, 0);
        complete(0, 1);
        chk(msip[0] == 1'b1, "R8 completion re-enables delivery", 64'(msip[0]), 64'd1);
        claim(0, "R8 source 1 delivered again");
        complete(0, 1); complete(0, 2); complete(0, 3);

        // R2/R3: second word, hart 33 -> source 34 (word 1 bit 2)
        wr_prio(34, 32'd1);
        wr_en(33, 1, 32'h4);
        rd_en(33, 1, "R3 enable word 1 readback");
        rd_en(32, 1, "R3 other context unaffected");
        wr_pend(1, 32'h4);
        rd_pend(1, "R2 pending word 1");
        chk(msip[33] == 1'b1, "R2 hart 33 signalled", 64'(msip[33]), 64'd1);
        wr_pend(1, 32'h0);
        rd_pend(1, "R2 zero write keeps pending");
        claim(33, "R6 claim source 34");
        chk(last_claim[33] == 34, "R6 source 34 returned", 64'(last_claim[33]), 64'd34);
        complete(33, 34);

        // R9: out of range accesses
        wr_en(NH, 0, 32'hFFFF_FFFF);
        rd_en(NH, 0, "R9 context beyond hart count reads 0");
        claim(NH + 3, "R9 claim beyond hart count reads 0");
        wr_prio(NS, 32'h3);
        rd_prio(NS, "R9 priority beyond last source reads 0");
        rd_pend(2, "R9 pending word beyond last reads 0");
        bus_op(1'b1, 16'h1001, 32'hFFFF_FFFF, rd);
        rd_pend(0, "R9 misaligned write ignored");
        bus_op(1'b0, 16'h8000, '0, rd);
        chk(rd == '0, "R9 unmapped read 0", 64'(rd), 64'd0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r, c, s, w;
            r = $urandom_range(0, 9);
            c = $urandom_range(0, 7);
            case (r)
                0, 1: begin
                    w = $urandom_range(0, 1);
                    wr_pend(w, 32'h1 << (w == 0 ? $urandom_range(0, 8) : $urandom_range(0, 5)));
                end
                2: wr_en(c, $urandom_range(0, 1), $urandom());
                3: wr_prio($urandom_range(0, NS), $urandom());
                4, 5: claim(c, "R6 random claim");
                6, 7: begin
                    s = ($urandom_range(0, 3) != 0) ? last_claim[c] : $urandom_range(0, NS);
                    complete(c, s);
                end
                8: begin
                    case ($urandom_range(0, 2))
                        0: rd_pend($urandom_range(0, 1), "R2 random pending read");
                        1: rd_en(c, $urandom_range(0, 1), "R3 random enable read");
                        default: rd_prio($urandom_range(0, NS), "R4 random priority read");
                    endcase
                end
                default: begin
                    if ($urandom_range(0, 1) == 1) wr_en(NH + 2, 0, $urandom());
                    else claim(NH + 1, "R9 random out-of-range claim");
                end
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule